// File: doc/BRIEF.md
# Clock Output Stop Gating Controller

This block sits between the free-running source clocks of a clock generator and its output buffers. For every output it decides, on its own source clock, whether the output toggles, is held low and driven, or has its driver released to high impedance. The decision combines four things: a per-output enable from the configuration registers, a global halt pin, two active-low clock-request pins, and stop-mask bits that say which outputs a request pin may stop. A configuration bit also picks whether an output stopped by a request stays driven or floats.

The outputs are ordered by class. The CPU differential pairs come first, then the SRC differential pairs, then the spare SRCS differential pairs, and the single-ended outputs come last. Each output has its own gating cell. The halt pin and the request pins are asynchronous. Each cell passes them through a two-flop synchronizer on the rising edge of its own source clock. It changes its gating state only on a falling edge, so every high pulse reaches the pin either whole or not at all.

Top module: `ckg_top`

## Requirements
- R1: An enabled CPU differential output (indices below N_CPU) keeps toggling whatever the level of `halt_i` and of the request pins.
- R2: While `halt_i` is 1, every enabled non-CPU output is held low and driven: true leg 0, complement leg 1, drive enable 1. This holds even when a request pin would stop the output and `stop_tristate_i` is 1.
- R3: While `clkreq_ni[0]` is 1, SRC output i stops if `stop_mask0_i[i]` is 1. While `clkreq_ni[0]` is 0, that output runs.
- R4: An SRC or SRCS output whose stop-mask bit is 0 runs whatever the level of its request pin.
- R5: While `clkreq_ni[1]` is 1, SRCS output j stops if `stop_mask1_i[j]` is 1. While `clkreq_ni[1]` is 0, that output runs.
- R6: An output stopped by a request pin is driven with true 0 and complement 1 when `stop_tristate_i` is 0. It has `drive_en_o` 0 when `stop_tristate_i` is 1.
- R7: `out_en_i[k]` = 0 puts a differential output in high impedance (`drive_en_o[k]` 0). It holds a single-ended output low with `drive_en_o[k]` 1. A disabled output takes precedence over both halt and request.
- R8: A running output follows its source clock on the true leg. On a differential output the complement leg carries the inverse of the source clock.
- R9: The gating state changes only while the source clock is low. A pin change made while the clock is low, before rising edge A, leaves the pulses at rising edges A and A+1 as before. It first changes the pulse at edge A+2.
- R10: While `rst_ni` is 0, all true legs are 0, all complement legs are 1 and all drive enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | N_OUT | Free-running source clock of each output |
| out_en_i | input | N_OUT | Per-output enable from the configuration registers |
| stop_mask0_i | input | N_SRC | SRC outputs that request pin 0 may stop |
| stop_mask1_i | input | N_SRCS | SRCS outputs that request pin 1 may stop |
| stop_tristate_i | input | 1 | 1: request-stopped outputs float; 0: driven low |
| halt_i | input | 1 | Global halt, asynchronous, active high |
| clkreq_ni | input | 2 | Active-low clock-request pins, asynchronous |
| clk_true_o | output | N_OUT | Gated true leg (the single-ended value for single-ended outputs) |
| clk_comp_o | output | N_DIFF | Gated complement leg of the differential outputs |
| drive_en_o | output | N_OUT | Output driver enable; 0 means high impedance |

## Verification
The assertions check several properties on every cycle of every output's own clock. A true leg is never high while its source clock is low. The two legs of a driven differential pair are always opposite. Disabled differential outputs float, single-ended outputs are always driven, and enabled CPU pairs always run. Only the bench's scenarios can show the rest, because those checks need an expected value worked out from the pin and mask combination. That covers which SRC and SRCS outputs a request pin stops, the choice between a driven stop and a floating stop, the priority of disable over halt over request, and the exact rising edge at which a pin change first takes effect.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    // Gating state of one output, updated on the falling edge of its clock.
    typedef enum logic [1:0] {
        CK_RUN = 2'd0,
        CK_LOW = 2'd1,
        CK_HIZ = 2'd2
    } ck_state_e;

    // Register set of one gating cell.
    typedef struct packed {
        ck_state_e state;
    } cell_regs_t;

    // Request source that a cell listens to.
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_PIN0 = 2'd1,
        REQ_PIN1 = 2'd2
    } req_src_e;

    // Output class of index k, given the group sizes.
    function automatic logic is_cpu(input int k, input int n_cpu);
        return k < n_cpu;
    endfunction

    function automatic logic is_diff(input int k, input int n_diff);
        return k < n_diff;
    endfunction

endpackage

// File: rtl/ckg_sync2.sv
module ckg_sync2 #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_regs_t;

    sync_regs_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = async_i;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.stable;

endmodule

// File: rtl/ckg_cell.sv
module ckg_cell
    import ckg_pkg::*;
#(
    parameter bit IS_DIFF     = 1'b1,
    parameter bit HALT_EXEMPT = 1'b0,
    parameter bit REQ_ON      = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic halt_ai,
    input  logic req_ai,
    input  logic mask_i,
    input  logic tristate_i,
    output logic run_o,
    output logic oe_o
);

    logic [1:0] pins_s;
    logic       halt_s;
    logic       req_s;
    logic       halt_hit;
    logic       req_hit;

    // The asynchronous pins are synchronized in this cell's own clock domain.
    ckg_sync2 #(
        .W(2)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({halt_ai, req_ai}),
        .sync_o (pins_s)
    );

    assign halt_s = pins_s[1];
    assign req_s  = pins_s[0];

    cell_regs_t cell_d, cell_q;

    always_comb begin
        cell_d   = cell_q;
        halt_hit = !HALT_EXEMPT && halt_s;
        req_hit  = REQ_ON && mask_i && req_s;
        // Priority order: disabled, then halted, then stopped by request.
        if (!en_i) begin
            cell_d.state = IS_DIFF ? CK_HIZ : CK_LOW;
        end else if (halt_hit) begin
            cell_d.state = CK_LOW;
        end else if (req_hit) begin
            cell_d.state = tristate_i ? CK_HIZ : CK_LOW;
        end else begin
            cell_d.state = CK_RUN;
        end
    end

    // State is taken on the falling edge only, so it changes while the clock is low.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cell_q.state <= CK_LOW;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign run_o = (cell_q.state == CK_RUN);
    assign oe_o  = (cell_q.state != CK_HIZ);

endmodule

// File: rtl/ckg_top.sv
module ckg_top
    import ckg_pkg::*;
#(
    parameter int N_CPU  = 2,
    parameter int N_SRC  = 6,
    parameter int N_SRCS = 2,
    parameter int N_SE   = 6,
    localparam int N_DIFF = N_CPU + N_SRC + N_SRCS,
    localparam int N_OUT  = N_DIFF + N_SE
) (
    input  logic              rst_ni,
    input  logic [N_OUT-1:0]  src_clk_i,
    input  logic [N_OUT-1:0]  out_en_i,
    input  logic [N_SRC-1:0]  stop_mask0_i,
    input  logic [N_SRCS-1:0] stop_mask1_i,
    input  logic              stop_tristate_i,
    input  logic              halt_i,
    input  logic [1:0]        clkreq_ni,
    output logic [N_OUT-1:0]  clk_true_o,
    output logic [N_DIFF-1:0] clk_comp_o,
    output logic [N_OUT-1:0]  drive_en_o
);

    localparam int SRC_LO  = N_CPU;
    localparam int SRCS_LO = N_CPU + N_SRC;

    logic [N_OUT-1:0] run_w;
    logic [N_OUT-1:0] oe_w;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        if (k < SRC_LO) begin : g_cpu
            ckg_cell #(
                .IS_DIFF(1'b1), .HALT_EXEMPT(1'b1), .REQ_ON(1'b0)
            ) u_cell (
                .clk_i(src_clk_i[k]), .rst_ni(rst_ni), .en_i(out_en_i[k]),
                .halt_ai(halt_i), .req_ai(1'b0), .mask_i(1'b0),
                .tristate_i(stop_tristate_i), .run_o(run_w[k]), .oe_o(oe_w[k])
            );
        end else if (k < SRCS_LO) begin : g_src
            ckg_cell #(
                .IS_DIFF(1'b1), .HALT_EXEMPT(1'b0), .REQ_ON(1'b1)
            ) u_cell (
                .clk_i(src_clk_i[k]), .rst_ni(rst_ni), .en_i(out_en_i[k]),
                .halt_ai(halt_i), .req_ai(clkreq_ni[0]),
                .mask_i(stop_mask0_i[k-SRC_LO]),
                .tristate_i(stop_tristate_i), .run_o(run_w[k]), .oe_o(oe_w[k])
            );
        end else if (k < N_DIFF) begin : g_srcs
            ckg_cell #(
                .IS_DIFF(1'b1), .HALT_EXEMPT(1'b0), .REQ_ON(1'b1)
            ) u_cell (
                .clk_i(src_clk_i[k]), .rst_ni(rst_ni), .en_i(out_en_i[k]),
                .halt_ai(halt_i), .req_ai(clkreq_ni[1]),
                .mask_i(stop_mask1_i[k-SRCS_LO]),
                .tristate_i(stop_tristate_i), .run_o(run_w[k]), .oe_o(oe_w[k])
            );
        end else begin : g_se
            ckg_cell #(
                .IS_DIFF(1'b0), .HALT_EXEMPT(1'b0), .REQ_ON(1'b0)
            ) u_cell (
                .clk_i(src_clk_i[k]), .rst_ni(rst_ni), .en_i(out_en_i[k]),
                .halt_ai(halt_i), .req_ai(1'b0), .mask_i(1'b0),
                .tristate_i(stop_tristate_i), .run_o(run_w[k]), .oe_o(oe_w[k])
            );
        end

        // The true leg is an AND with a falling-edge state, so it has no runt pulses.
        assign clk_true_o[k] = src_clk_i[k] & run_w[k];
        assign drive_en_o[k] = oe_w[k];

        if (k < N_DIFF) begin : g_comp
            // Complement: inverse clock while running, 1 when held low, 0 when floating.
            assign clk_comp_o[k] = run_w[k] ? ~src_clk_i[k] : oe_w[k];
        end
    end

endmodule

// File: rtl/ckg_top_chk.sv
module ckg_top_chk #(
    parameter int N_CPU  = 2,
    parameter int N_SRC  = 6,
    parameter int N_SRCS = 2,
    parameter int N_SE   = 6,
    localparam int N_DIFF = N_CPU + N_SRC + N_SRCS,
    localparam int N_OUT  = N_DIFF + N_SE
) (
    input logic              rst_ni,
    input logic [N_OUT-1:0]  src_clk_i,
    input logic [N_OUT-1:0]  out_en_i,
    input logic [N_OUT-1:0]  clk_true_o,
    input logic [N_DIFF-1:0] clk_comp_o,
    input logic [N_OUT-1:0]  drive_en_o
);

    // R10: reset state of every leg
    p_reset_state_r10: assert property (@(posedge src_clk_i[0])
        !rst_ni |-> (clk_true_o == '0 && (&clk_comp_o) && (&drive_en_o)));

    for (genvar k = 0; k < N_OUT; k++) begin : g_chk
        logic armed_q;

        always_ff @(negedge src_clk_i[k] or negedge rst_ni) begin
            if (!rst_ni) begin
                armed_q <= 1'b0;
            end else begin
                armed_q <= 1'b1;
            end
        end

        // R9: no pulse may begin while the source clock is low
        p_quiet_low_r9: assert property (@(posedge src_clk_i[k])
            disable iff (!rst_ni) !clk_true_o[k]);

        if (k < N_CPU) begin : g_cpu
            // R1: an enabled CPU pair always toggles
            p_cpu_runs_r1: assert property (@(negedge src_clk_i[k])
                disable iff (!rst_ni)
                (armed_q && $past(out_en_i[k])) |-> (clk_true_o[k] && drive_en_o[k]));
        end

        if (k < N_DIFF) begin : g_diff
            // R7: a disabled differential output floats
            p_off_hiz_r7: assert property (@(negedge src_clk_i[k])
                disable iff (!rst_ni)
                (armed_q && !$past(out_en_i[k])) |-> !drive_en_o[k]);
            // R8: driven legs are always opposite
            p_legs_opposite_r8: assert property (@(negedge src_clk_i[k])
                disable iff (!rst_ni)
                drive_en_o[k] |-> (clk_comp_o[k] != clk_true_o[k]));
        end else begin : g_se
            // R7: a single-ended output is never floated
            p_se_driven_r7: assert property (@(negedge src_clk_i[k])
                disable iff (!rst_ni) drive_en_o[k]);
        end
    end

endmodule

bind ckg_top ckg_top_chk #(
    .N_CPU(N_CPU), .N_SRC(N_SRC), .N_SRCS(N_SRCS), .N_SE(N_SE)
) u_chk (
    .rst_ni    (rst_ni),
    .src_clk_i (src_clk_i),
    .out_en_i  (out_en_i),
    .clk_true_o(clk_true_o),
    .clk_comp_o(clk_comp_o),
    .drive_en_o(drive_en_o)
);

// File: tb/ckg_top_test.sv
module ckg_top_test;

    localparam int N_CPU  = 2;
    localparam int N_SRC  = 6;
    localparam int N_SRCS = 2;
    localparam int N_SE   = 6;
    localparam int N_DIFF = N_CPU + N_SRC + N_SRCS;
    localparam int N_OUT  = N_DIFF + N_SE;
    localparam int SE0    = N_DIFF;

    logic              clk = 1'b0;
    logic              rst_ni;
    logic [N_OUT-1:0]  out_en;
    logic [N_SRC-1:0]  mask0;
    logic [N_SRCS-1:0] mask1;
    logic              tri_mode;
    logic              halt;
    logic [1:0]        req_n;
    logic [N_OUT-1:0]  t_o;
    logic [N_DIFF-1:0] c_o;
    logic [N_OUT-1:0]  oe_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ckg_top #(
        .N_CPU(N_CPU), .N_SRC(N_SRC), .N_SRCS(N_SRCS), .N_SE(N_SE)
    ) uut (
        .rst_ni(rst_ni), .src_clk_i({N_OUT{clk}}), .out_en_i(out_en),
        .stop_mask0_i(mask0), .stop_mask1_i(mask1), .stop_tristate_i(tri_mode),
        .halt_i(halt), .clkreq_ni(req_n), .clk_true_o(t_o), .clk_comp_o(c_o),
        .drive_en_o(oe_o)
    );

    typedef struct {
        logic [N_OUT-1:0]  t_hi;
        logic [N_DIFF-1:0] c_hi;
        logic [N_DIFF-1:0] c_lo;
        logic [N_OUT-1:0]  oe;
        string             tag;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected state per output from the requirements: 0 run, 1 held low, 2 floating.
    function automatic int exp_state(input int k);
        bit stop_req;
        if (!out_en[k]) return (k < N_DIFF) ? 2 : 1;                      // R7
        if (k < N_CPU) return 0;                                          // R1
        if (halt) return 1;                                               // R2
        stop_req = 1'b0;
        if (k >= N_CPU && k < N_CPU + N_SRC) stop_req = mask0[k-N_CPU] && req_n[0];   // R3 R4
        else if (k >= N_CPU + N_SRC && k < N_DIFF)
            stop_req = mask1[k-N_CPU-N_SRC] && req_n[1];                  // R5 R4
        if (stop_req) return tri_mode ? 2 : 1;                            // R6
        return 0;
    endfunction

    task automatic expect_now(input string tag);
        exp_t e;
        e.tag = tag;
        for (int k = 0; k < N_OUT; k++) begin
            int s;
            s = exp_state(k);
            e.t_hi[k] = (s == 0);
            e.oe[k]   = (s != 2);
            if (k < N_DIFF) begin
                e.c_hi[k] = (s == 1);
                e.c_lo[k] = (s != 2);
            end
        end
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    // Driver: apply at clock low, let synchronizers settle, then expect.
    task automatic apply_and_expect(input string tag);
        repeat (4) @(posedge clk);
        expect_now(tag);
    endtask

    // Monitor: samples one high phase and one low phase per expected item.
    initial begin : monitor
        forever begin
            exp_t e;
            logic [N_OUT-1:0]  th, tl;
            logic [N_DIFF-1:0] ch, cl, dm;
            logic [N_OUT-1:0]  om;
            wait (sb_q.size() > 0);
            e = sb_q[0];
            @(posedge clk); #2;
            th = t_o; ch = c_o; om = oe_o;
            @(negedge clk); #2;
            tl = t_o; cl = c_o;
            dm = e.oe[N_DIFF-1:0];
            check({e.tag, " drive_en"}, 64'(om), 64'(e.oe));
            check({e.tag, " true high phase"}, 64'(th & e.oe), 64'(e.t_hi & e.oe));
            check({e.tag, " true low phase"}, 64'(tl & e.oe), 64'(0));
            check({e.tag, " comp high phase"}, 64'(ch & dm), 64'(e.c_hi & dm));
            check({e.tag, " comp low phase"}, 64'(cl & dm), 64'(e.c_lo & dm));
            void'(sb_q.pop_front());
        end
    end

    initial begin : watchdog
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stimulus
        rst_ni   = 1'b0;
        out_en   = '1;
        mask0    = '0;
        mask1    = '0;
        tri_mode = 1'b1;
        halt     = 1'b0;
        req_n    = 2'b00;
        repeat (3) @(posedge clk);
        #2;
        // R10
        check("R10 true in reset", 64'(t_o), 64'(0));
        check("R10 comp in reset", 64'(c_o), 64'({N_DIFF{1'b1}}));
        check("R10 drive_en in reset", 64'(oe_o), 64'({N_OUT{1'b1}}));
        @(negedge clk); #1;
        rst_ni = 1'b1;
        apply_and_expect("R8 all running");

        @(negedge clk); #1;
        halt = 1'b1;
        apply_and_expect("R1 R2 halt");

        @(negedge clk); #1;
        mask0 = 6'b000101; req_n = 2'b01;
        apply_and_expect("R2 halt over floating request");

        @(negedge clk); #1;
        halt = 1'b0; tri_mode = 1'b0;
        apply_and_expect("R3 R4 R6 driven stop");

        @(negedge clk); #1;
        tri_mode = 1'b1;
        apply_and_expect("R6 floating stop");

        @(negedge clk); #1;
        req_n = 2'b00;
        apply_and_expect("R3 request released");

        @(negedge clk); #1;
        mask0 = '0; mask1 = 2'b10; req_n = 2'b11;
        apply_and_expect("R5 R4 request pin 1");

        @(negedge clk); #1;
        tri_mode = 1'b0;
        apply_and_expect("R5 driven stop");

        @(negedge clk); #1;
        req_n = 2'b00; mask1 = '0;
        out_en = ~(16'b0000_1010_0000_0101);
        apply_and_expect("R7 disable mix");

        @(negedge clk); #1;
        halt = 1'b1; mask0 = '1; req_n = 2'b11; tri_mode = 1'b0;
        apply_and_expect("R7 disable over halt");

        @(negedge clk); #1;
        halt = 1'b0; mask0 = '0; req_n = 2'b00; out_en = '1;
        apply_and_expect("R8 all running again");

        // R9: exact edge at which a halt change first shows on a single-ended output.
        @(negedge clk); #1;
        halt = 1'b1;
        @(posedge clk); #2; check("R9 halt edge A", 64'(t_o[SE0]), 64'(1));
        @(posedge clk); #2; check("R9 halt edge A+1", 64'(t_o[SE0]), 64'(1));
        @(posedge clk); #2; check("R9 halt edge A+2", 64'(t_o[SE0]), 64'(0));
        check("R1 CPU during halt edge", 64'(t_o[0]), 64'(1));
        @(negedge clk); #1;
        halt = 1'b0;
        @(posedge clk); #2; check("R9 resume edge A", 64'(t_o[SE0]), 64'(0));
        @(posedge clk); #2; check("R9 resume edge A+1", 64'(t_o[SE0]), 64'(0));
        @(posedge clk); #2; check("R9 resume edge A+2", 64'(t_o[SE0]), 64'(1));

        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule